// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is an interval timer. Software writes a reload value and then starts the timer. From then on the counter steps down by one on every falling edge of a chosen count clock. When a falling edge finds the counter at zero, the timer underflows. An underflow raises a one-cycle interrupt pulse, toggles a square-wave output and reloads the counter. The reloaded value becomes visible only at the next rising edge of the count clock, so each underflow is followed by a defined reload window.

Two slow clock sources reach the block as plain level signals. Each one passes through its own synchronizer and edge detector, which run in the single system-clock domain. A control bit picks which source drives the counter. At the moment of underflow, the reload value is copied into a shadow register. A reload write that lands inside the window therefore cannot disturb the value being loaded.

The sequencing is a three-state machine:
- Stopped (`ST_IDLE`).
- Counting (`ST_COUNT`).
- Reload window (`ST_RELOAD`).

Its transitions are:
- Start: a run write moves Stopped to Counting and loads the counter.
- Underflow: Counting moves to Reload window in continuous mode, or to Stopped in one-shot mode.
- Commit: a rising edge moves Reload window to Counting.
- Halt: a stop write moves Counting or Reload window to Stopped.

Top module: `ivtimer`

## Requirements
- R1: After reset the count is 0 and `running_o`, `irq_o` and `tout_o` are all low.
- R2: A control write with run=1 while stopped loads the count from the reload register and sets `running_o`. The same write while already running does not reload.
- R3: While counting, the count decreases by one on each falling edge of the selected source. Rising edges do not change it.
- R4: A falling edge that finds the count at 0 produces exactly one `irq_o` pulse, one system clock long.
- R5: After an underflow the count reads 0 until the next rising edge of the selected source. From that edge it reads the reload value. For example, reload 0x25 gives the sequence 0x03, 0x02, 0x01, 0x00, 0x25, 0x24.
- R6: The value loaded after an underflow is the reload register content at the underflow. A reload write inside the window takes effect only at the following underflow.
- R7: In continuous mode (oneshot=0) the timer keeps counting and underflowing indefinitely.
- R8: In one-shot mode (oneshot=1) the first underflow clears `running_o`. The count then stays 0 and no further interrupts occur.
- R9: Source select value 0 picks `src_fast_i` and value 1 picks `src_slow_i`. Edges on the unselected source have no effect.
- R10: With output enable set, `tout_o` toggles on every underflow, starting from 0 after reset. With output enable clear, `tout_o` is held low.
- R11: A control write with run=0 clears `running_o`, and the count then holds its value through any source edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_fast_i | input | 1 | High-speed count clock, level signal |
| src_slow_i | input | 1 | Low-speed count clock, level signal |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_data_i | input | CNT_W | Reload value to write |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_run_i | input | 1 | Run (1) or stop (0) |
| ctrl_oneshot_i | input | 1 | 1 = one-shot, 0 = continuous |
| ctrl_src_i | input | 1 | 0 = fast source, 1 = slow source |
| ctrl_oe_i | input | 1 | Timer output enable |
| count_o | output | CNT_W | Current count readback |
| running_o | output | 1 | Run bit readback |
| irq_o | output | 1 | Underflow interrupt pulse |
| tout_o | output | 1 | Square-wave timer output |

## Verification
The bench builds the block with CNT_W=8 and SYNC_STAGES=2. The 8-bit width lets the bench load 0x25 and reproduce the 0x03-to-0x24 reload sequence. Short reloads of 1 and 3 reach an underflow within a few ticks, which brings the reload window, the shadow capture, one-shot stop and the tout toggle parity into reach cheaply. With two synchronizer stages, a source edge reaches the counter three system clocks after it occurs. The bench therefore holds each source level for five clocks, which leaves every count change settled before it is sampled.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_RELOAD = 2'd2
    } ivt_state_e;
endpackage

// File: rtl/ivt_edge_sync.sv
module ivt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[PIPE_W-2:0], lvl_i};
    end

    // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
    assign fall_o =  pipe_q[STAGES] & ~pipe_q[STAGES-1];
    assign rise_o = ~pipe_q[STAGES] &  pipe_q[STAGES-1];
endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             tgl_o,
    output ivt_state_e       state_o
);
    ivt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, shadow_q;
    logic             irq_q, tgl_q;
    logic             hit;

    assign hit = (state_q == ST_COUNT) && fall_i && !stop_i && (count_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: Start, Underflow, Commit, Halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_COUNT;
            ST_COUNT: begin
                if (stop_i)   state_d = ST_IDLE;
                else if (hit) state_d = oneshot_i ? ST_IDLE : ST_RELOAD;
            end
            ST_RELOAD: begin
                if (stop_i)      state_d = ST_IDLE;
                else if (rise_i) state_d = ST_COUNT;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            shadow_q <= '0;
            irq_q    <= 1'b0;
            tgl_q    <= 1'b0;
        end else begin
            irq_q <= hit;
            if (hit) tgl_q <= ~tgl_q;
            unique case (state_q)
                ST_IDLE: if (start_i) count_q <= reload_i;
                ST_COUNT: begin
                    if (!stop_i && fall_i) begin
                        if (count_q == '0) shadow_q <= reload_i;
                        else               count_q  <= count_q - CNT_W'(1);
                    end
                end
                ST_RELOAD: if (!stop_i && rise_i) count_q <= shadow_q;
                default: ;
            endcase
        end
    end

    assign count_o = count_q;
    assign irq_o   = irq_q;
    assign tgl_o   = tgl_q;
    assign state_o = state_q;
endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_fast_i,
    input  logic             src_slow_i,
    input  logic             reload_we_i,
    input  logic [CNT_W-1:0] reload_data_i,
    input  logic             ctrl_we_i,
    input  logic             ctrl_run_i,
    input  logic             ctrl_oneshot_i,
    input  logic             ctrl_src_i,
    input  logic             ctrl_oe_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             irq_o,
    output logic             tout_o
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0] src_lvl, src_fall, src_rise;
    logic [CNT_W-1:0]   reload_q;
    logic               oneshot_q, src_q, oe_q, tgl;
    ivt_state_e         core_state;

    assign src_lvl = {src_slow_i, src_fast_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        ivt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (src_lvl[g]),
            .fall_o (src_fall[g]),
            .rise_o (src_rise[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q  <= '0;
            oneshot_q <= 1'b0;
            src_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            if (reload_we_i) reload_q <= reload_data_i;
            if (ctrl_we_i) begin
                oneshot_q <= ctrl_oneshot_i;
                src_q     <= ctrl_src_i;
                oe_q      <= ctrl_oe_i;
            end
        end
    end

    ivt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (src_fall[src_q]),
        .rise_i    (src_rise[src_q]),
        .start_i   (ctrl_we_i & ctrl_run_i),
        .stop_i    (ctrl_we_i & ~ctrl_run_i),
        .oneshot_i (oneshot_q),
        .reload_i  (reload_q),
        .count_o   (count_o),
        .irq_o     (irq_o),
        .tgl_o     (tgl),
        .state_o   (core_state)
    );

    assign running_o = (core_state != ST_IDLE);
    assign tout_o    = oe_q & tgl;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             tout,
    input logic             running,
    input logic             oe,
    input logic             oneshot,
    input logic             ctrl_we,
    input ivt_state_e       st
);
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && $past(st) == ST_COUNT && !$stable(count))
            |-> count == $past(count) - CNT_W'(1));

    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r5_zero_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> count == '0);

    a_r8_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && oneshot && $stable(oneshot)) |-> !running);

    a_r10_tout_on_uflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tout) && $stable(oe)) |-> irq);

    a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_we) |=> $stable(count));
endmodule

bind ivtimer ivt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count_o),
    .irq     (irq_o),
    .tout    (tout_o),
    .running (running_o),
    .oe      (oe_q),
    .oneshot (oneshot_q),
    .ctrl_we (ctrl_we_i),
    .st      (core_state)
);

// File: tb/ivtimer_bench.sv
module ivtimer_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             src_fast_i = 1'b1, src_slow_i = 1'b1;
    logic             reload_we_i = 1'b0;
    logic [CNT_W-1:0] reload_data_i = '0;
    logic             ctrl_we_i = 1'b0, ctrl_run_i = 1'b0, ctrl_oneshot_i = 1'b0;
    logic             ctrl_src_i = 1'b0, ctrl_oe_i = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             running_o, irq_o, tout_o;

    int n_chk = 0, n_bad = 0, irq_seen = 0, uf_exp = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ivtimer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_ivtimer (.*);

    always @(negedge clk) if (rst_n && irq_o) irq_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reload(input logic [CNT_W-1:0] v);
        reload_data_i = v; reload_we_i = 1'b1;
        @(negedge clk); reload_we_i = 1'b0;
    endtask

    task automatic wr_ctrl(input bit run, input bit os, input bit src, input bit oe);
        ctrl_run_i = run; ctrl_oneshot_i = os; ctrl_src_i = src; ctrl_oe_i = oe;
        ctrl_we_i = 1'b1;
        @(negedge clk); ctrl_we_i = 1'b0;
    endtask

    task automatic fall(input bit s);
        if (s) src_slow_i = 1'b0; else src_fast_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic rise(input bit s);
        if (s) src_slow_i = 1'b1; else src_fast_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 running", running_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 tout", tout_o, 0);
    endtask

    task automatic t_load_count();
        wr_reload(8'd5);
        wr_ctrl(1, 0, 0, 1);
        chk("R2 load", count_o, 5);
        chk("R2 running", running_o, 1);
        fall(0); chk("R3 fall dec", count_o, 4);
        rise(0); chk("R3 rise no dec", count_o, 4);
        fall(0); rise(0); chk("R3 second dec", count_o, 3);
    endtask

    task automatic t_sequence();
        int base;
        wr_ctrl(0, 0, 0, 1);
        wr_reload(8'h03);
        wr_ctrl(1, 0, 0, 1);
        wr_reload(8'h25);
        chk("R5 seq 03", count_o, 8'h03);
        fall(0); rise(0); chk("R5 seq 02", count_o, 8'h02);
        fall(0); rise(0); chk("R5 seq 01", count_o, 8'h01);
        fall(0); rise(0); chk("R5 seq 00", count_o, 8'h00);
        base = irq_seen;
        fall(0); uf_exp++;
        chk("R4 one irq", irq_seen - base, 1);
        chk("R5 window zero", count_o, 0);
        chk("R10 tout toggled", tout_o, uf_exp % 2);
        rise(0); chk("R5 seq 25", count_o, 8'h25);
        fall(0); rise(0); chk("R5 seq 24", count_o, 8'h24);
    endtask

    task automatic t_shadow();
        int base;
        wr_ctrl(0, 0, 0, 1);
        wr_reload(8'd1);
        wr_ctrl(1, 0, 0, 1);
        base = irq_seen;
        fall(0); rise(0);
        fall(0); uf_exp++;
        wr_reload(8'd7);
        chk("R5 window zero", count_o, 0);
        rise(0); chk("R6 old value loaded", count_o, 1);
        fall(0); rise(0);
        fall(0); uf_exp++;
        rise(0); chk("R6 new value next", count_o, 7);
        chk("R7 continuous irqs", irq_seen - base, 2);
        chk("R7 still running", running_o, 1);
        chk("R10 tout parity", tout_o, uf_exp % 2);
    endtask

    task automatic t_src();
        fall(1); rise(1); chk("R9 slow ignored", count_o, 7);
        wr_ctrl(1, 0, 1, 1);
        chk("R2 no reload running", count_o, 7);
        fall(0); rise(0); chk("R9 fast ignored", count_o, 7);
        fall(1); rise(1); chk("R9 slow counts", count_o, 6);
    endtask

    task automatic t_oe();
        wr_ctrl(1, 0, 1, 0);
        chk("R10 disabled low", tout_o, 0);
        wr_ctrl(1, 0, 1, 1);
        chk("R10 re-enabled", tout_o, uf_exp % 2);
    endtask

    task automatic t_stop();
        wr_ctrl(0, 0, 1, 1);
        chk("R11 stopped", running_o, 0);
        fall(1); rise(1); chk("R11 count held", count_o, 6);
    endtask

    task automatic t_oneshot();
        int base;
        wr_reload(8'd1);
        wr_ctrl(1, 1, 0, 1);
        chk("R2 oneshot load", count_o, 1);
        base = irq_seen;
        fall(0); rise(0);
        fall(0); uf_exp++;
        chk("R8 irq", irq_seen - base, 1);
        chk("R8 run cleared", running_o, 0);
        chk("R8 count zero", count_o, 0);
        rise(0); fall(0); rise(0); fall(0); rise(0);
        chk("R8 stays zero", count_o, 0);
        chk("R8 no more irq", irq_seen - base, 1);
        chk("R10 tout parity", tout_o, uf_exp % 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_count();
        t_sequence();
        t_shadow();
        t_src();
        t_oe();
        t_stop();
        t_oneshot();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule